// File: doc/BRIEF.md
# Control Endpoint SETUP Capture Engine

This block sits behind the packet receiver of a USB device controller and handles the Setup stage of one control endpoint. The receiver gives a one-cycle strobe `setup_vld` together with the eight SETUP bytes. The engine never refuses such a packet. It turns every strobe into a fixed three-word record in the receive queue and forces the endpoint's IN and OUT NAK flags. It also counts the packet down on a small counter that software programs.

The receiver signals `stage_adv` when the transfer leaves the Setup stage for a data or status stage. The engine then appends one stage-done marker word to the queue. It watches the words that software pops from that queue. When the marker for its own endpoint is popped, it raises the setup interrupt and clears the OUT endpoint's enable in the same pulse. Software therefore sees the interrupt only after the whole Setup stage has been drained.

Two state machines do the work. The write machine has the states `WR_IDLE`, `WR_STAT`, `WR_LO`, `WR_HI` and `WR_MARK`, with these transitions:
- `WR_IDLE` goes to `WR_STAT` on a strobe. With no strobe and a pending marker request, it goes to `WR_MARK` instead.
- `WR_STAT` goes to `WR_LO`, then to `WR_HI`, then back to `WR_IDLE`.
- `WR_MARK` returns to `WR_IDLE`.

The phase machine has the states `PH_IDLE`, `PH_SETUP`, `PH_MARK_PEND` and `PH_DATA`, with these transitions:
- A strobe moves it from `PH_IDLE` or `PH_DATA` to `PH_SETUP`.
- `stage_adv` moves it from `PH_SETUP` to `PH_MARK_PEND`.
- The marker write moves it from `PH_MARK_PEND` to `PH_DATA`.
- All other inputs leave it where it is.

Top module: `ctl_setup_capture`

## Requirements
- R1: While and right after reset, `q_wr_en`, `nak_in_set`, `nak_out_set`, `setup_irq` and `ep_en_clr` are 0 and `cnt_val` is 0.
- R2: Take a strobe sampled at clock edge N. The engine then writes three queue words on the edges N+1, N+2 and N+3.
  - The first is a status word: bits [3:0] hold the endpoint number `EP_ID`, bits [14:4] hold the byte count 8, bits [18:15] hold type code 6, and all other bits are 0.
  - The second holds `setup_bytes[31:0]`, which are bytes 0 to 3 with byte 0 in bits [7:0].
  - The third holds `setup_bytes[63:32]`.
- R3: A strobe decrements `cnt_val` by one, and the new value is visible after edge N. At 0 the counter stays at 0. The record is written whatever the counter value is.
- R4: `cnt_load` loads `cnt_load_val` into the counter on the next edge. A load in the same cycle as a strobe wins over the decrement, and the record is still written.
- R5: `nak_in_set` and `nak_out_set` pulse together for exactly the one cycle in which the status word is written.
- R6: A `stage_adv` sampled at edge M after a SETUP, with the queue idle, writes one marker word on edge M+2. The marker has type code 4 in bits [18:15], byte count 0 and `EP_ID` in bits [3:0].
- R7: Only one marker is written per Setup stage. Repeated SETUPs before the marker add no second marker. A further `stage_adv`, or one with no SETUP before it, writes nothing.
- R8: When `pop_vld` carries a word with type code 4 and endpoint `EP_ID`, `setup_irq` and `ep_en_clr` pulse together for one cycle on the next edge. Popping any other word causes no pulse.
- R9: A marker pop in the same cycle as a new strobe gives both the interrupt pulse and the status word on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_vld | input | 1 | One-cycle strobe: SETUP packet received |
| setup_bytes | input | 64 | SETUP payload, byte 0 in bits [7:0] |
| stage_adv | input | 1 | Transfer has moved on to a data or status stage |
| cnt_load | input | 1 | Software write of the setup counter |
| cnt_load_val | input | CNT_W | Value to load into the counter |
| cnt_val | output | CNT_W | Current setup counter |
| q_wr_en | output | 1 | Receive-queue push strobe |
| q_wr_data | output | 32 | Receive-queue push word |
| pop_vld | input | 1 | Software popped a queue word this cycle |
| pop_word | input | 32 | The popped word |
| nak_in_set | output | 1 | Force the IN NAK flag of this endpoint |
| nak_out_set | output | 1 | Force the OUT NAK flag of this endpoint |
| setup_irq | output | 1 | Setup interrupt pulse |
| ep_en_clr | output | 1 | Clear the OUT endpoint enable |

## Verification
Two functions can coincide in one cycle.

The first pair is a software pop of the stage-done marker arriving in the same cycle as the strobe of a new SETUP. The bench drives both on one edge. On the next edge it expects the interrupt pulse and the status word, with the NAK pulses, to appear together.

The second pair is a counter load meeting the decrement of a SETUP strobe. The bench drives both in one cycle and checks two things: the counter shows the loaded value, and the record is still written in full.

// File: rtl/ctl_setup_pkg.sv
`timescale 1ns/1ps
package ctl_setup_pkg;
    localparam int WORD_W   = 32;
    localparam int EP_W     = 4;
    localparam int BCNT_W   = 11;
    localparam int TYPE_W   = 4;
    localparam int EP_LSB   = 0;
    localparam int BCNT_LSB = EP_LSB + EP_W;
    localparam int TYPE_LSB = BCNT_LSB + BCNT_W;
    localparam int PAD_W    = WORD_W - TYPE_LSB - TYPE_W;
    localparam int SETUP_BYTES = 8;
    localparam int PAYLOAD_W   = SETUP_BYTES * 8;

    localparam logic [TYPE_W-1:0] PKT_SETUP = 4'd6;
    localparam logic [TYPE_W-1:0] PKT_DONE  = 4'd4;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_STAT,
        WR_LO,
        WR_HI,
        WR_MARK
    } wr_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_MARK_PEND,
        PH_DATA
    } ph_state_t;

    function automatic logic [WORD_W-1:0] make_status(
        input logic [TYPE_W-1:0] typ,
        input logic [BCNT_W-1:0] bcnt,
        input logic [EP_W-1:0]   ep
    );
        return {{PAD_W{1'b0}}, typ, bcnt, ep};
    endfunction
endpackage

// File: rtl/ctl_setup_counter.sv
`timescale 1ns/1ps
module ctl_setup_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != CNT_ZERO)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ctl_setup_phase.sv
`timescale 1ns/1ps
module ctl_setup_phase
    import ctl_setup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic setup_vld,
    input  logic stage_adv,
    input  logic mark_ack,
    output logic mark_req
);
    ph_state_t ph_q;
    ph_state_t ph_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: begin
                if (setup_vld) ph_d = PH_SETUP;
            end
            PH_SETUP: begin
                if (stage_adv && !setup_vld) ph_d = PH_MARK_PEND;
            end
            PH_MARK_PEND: begin
                if (mark_ack) ph_d = PH_DATA;
            end
            PH_DATA: begin
                if (setup_vld) ph_d = PH_SETUP;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_comb begin
        mark_req = 1'b0;
        unique case (ph_q)
            PH_MARK_PEND: mark_req = 1'b1;
            default:      mark_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_setup_writer.sv
`timescale 1ns/1ps
module ctl_setup_writer
    import ctl_setup_pkg::*;
#(
    parameter int unsigned EP_ID = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 setup_vld,
    input  logic [PAYLOAD_W-1:0] setup_bytes,
    input  logic                 mark_req,
    output logic                 mark_ack,
    output logic                 q_wr_en,
    output logic [WORD_W-1:0]    q_wr_data,
    output logic                 nak_pulse
);
    localparam logic [EP_W-1:0]   EP_CODE   = EP_W'(EP_ID);
    localparam logic [BCNT_W-1:0] SETUP_LEN = BCNT_W'(SETUP_BYTES);
    localparam int                HALF_W    = PAYLOAD_W / 2;

    wr_state_t            st_q;
    wr_state_t            st_d;
    logic [PAYLOAD_W-1:0] bytes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= WR_IDLE;
            bytes_q <= '0;
        end else begin
            st_q <= st_d;
            if (setup_vld && (st_q == WR_IDLE)) begin
                bytes_q <= setup_bytes;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WR_IDLE: begin
                if (setup_vld)     st_d = WR_STAT;
                else if (mark_req) st_d = WR_MARK;
            end
            WR_STAT: st_d = WR_LO;
            WR_LO:   st_d = WR_HI;
            WR_HI:   st_d = WR_IDLE;
            WR_MARK: st_d = WR_IDLE;
            default: st_d = WR_IDLE;
        endcase
    end

    always_comb begin
        q_wr_en   = 1'b0;
        q_wr_data = '0;
        nak_pulse = 1'b0;
        mark_ack  = 1'b0;
        unique case (st_q)
            WR_IDLE: begin
                q_wr_en = 1'b0;
            end
            WR_STAT: begin
                q_wr_en   = 1'b1;
                q_wr_data = make_status(PKT_SETUP, SETUP_LEN, EP_CODE);
                nak_pulse = 1'b1;
            end
            WR_LO: begin
                q_wr_en   = 1'b1;
                q_wr_data = bytes_q[HALF_W-1:0];
            end
            WR_HI: begin
                q_wr_en   = 1'b1;
                q_wr_data = bytes_q[PAYLOAD_W-1:HALF_W];
            end
            WR_MARK: begin
                q_wr_en   = 1'b1;
                q_wr_data = make_status(PKT_DONE, '0, EP_CODE);
                mark_ack  = 1'b1;
            end
            default: q_wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_setup_irq.sv
`timescale 1ns/1ps
module ctl_setup_irq
    import ctl_setup_pkg::*;
#(
    parameter int unsigned EP_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_vld,
    input  logic [WORD_W-1:0] pop_word,
    output logic              irq_pulse
);
    localparam logic [EP_W-1:0] EP_CODE = EP_W'(EP_ID);

    logic is_marker;
    logic irq_q;

    always_comb begin
        is_marker = pop_vld
                 && (pop_word[TYPE_LSB +: TYPE_W] == PKT_DONE)
                 && (pop_word[EP_LSB +: EP_W] == EP_CODE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= is_marker;
        end
    end

    assign irq_pulse = irq_q;
endmodule

// File: rtl/ctl_setup_capture.sv
`timescale 1ns/1ps
module ctl_setup_capture
    import ctl_setup_pkg::*;
#(
    parameter int unsigned EP_ID = 0,
    parameter int          CNT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 setup_vld,
    input  logic [PAYLOAD_W-1:0] setup_bytes,
    input  logic                 stage_adv,
    input  logic                 cnt_load,
    input  logic [CNT_W-1:0]     cnt_load_val,
    output logic [CNT_W-1:0]     cnt_val,
    output logic                 q_wr_en,
    output logic [WORD_W-1:0]    q_wr_data,
    input  logic                 pop_vld,
    input  logic [WORD_W-1:0]    pop_word,
    output logic                 nak_in_set,
    output logic                 nak_out_set,
    output logic                 setup_irq,
    output logic                 ep_en_clr
);
    logic mark_req;
    logic mark_ack;
    logic nak_pulse;
    logic irq_pulse;

    ctl_setup_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (setup_vld),
        .cnt      (cnt_val)
    );

    ctl_setup_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_vld (setup_vld),
        .stage_adv (stage_adv),
        .mark_ack  (mark_ack),
        .mark_req  (mark_req)
    );

    ctl_setup_writer #(.EP_ID(EP_ID)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_vld   (setup_vld),
        .setup_bytes (setup_bytes),
        .mark_req    (mark_req),
        .mark_ack    (mark_ack),
        .q_wr_en     (q_wr_en),
        .q_wr_data   (q_wr_data),
        .nak_pulse   (nak_pulse)
    );

    ctl_setup_irq #(.EP_ID(EP_ID)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_vld   (pop_vld),
        .pop_word  (pop_word),
        .irq_pulse (irq_pulse)
    );

    assign nak_in_set  = nak_pulse;
    assign nak_out_set = nak_pulse;
    assign setup_irq   = irq_pulse;
    assign ep_en_clr   = irq_pulse;
endmodule

// File: rtl/ctl_setup_capture_chk.sv
`timescale 1ns/1ps
module ctl_setup_capture_chk
    import ctl_setup_pkg::*;
#(
    parameter int unsigned EP_ID = 0,
    parameter int          CNT_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 setup_vld,
    input logic [PAYLOAD_W-1:0] setup_bytes,
    input logic                 stage_adv,
    input logic                 cnt_load,
    input logic [CNT_W-1:0]     cnt_load_val,
    input logic [CNT_W-1:0]     cnt_val,
    input logic                 q_wr_en,
    input logic [WORD_W-1:0]    q_wr_data,
    input logic                 pop_vld,
    input logic [WORD_W-1:0]    pop_word,
    input logic                 nak_in_set,
    input logic                 nak_out_set,
    input logic                 setup_irq,
    input logic                 ep_en_clr
);
    // R5
    nak_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nak_in_set == nak_out_set);

    // R5
    nak_on_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nak_in_set |-> (q_wr_en && (q_wr_data[TYPE_LSB +: TYPE_W] == PKT_SETUP)));

    // R2
    strobe_to_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_vld |=> nak_in_set);

    // R2
    record_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nak_in_set |=> (q_wr_en && !nak_in_set) ##1 (q_wr_en && !nak_in_set));

    // R3
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_vld && !cnt_load && (cnt_val != '0))
        |=> (cnt_val == CNT_W'($past(cnt_val) - 1'b1)));

    // R3
    cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_vld && !cnt_load && (cnt_val == '0)) |=> (cnt_val == '0));

    // R4
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt_val == $past(cnt_load_val)));

    // R8
    irq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_irq == ep_en_clr);

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_irq |-> $past(pop_vld));
endmodule

bind ctl_setup_capture ctl_setup_capture_chk #(.EP_ID(EP_ID), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_ctl_setup_capture.sv
`timescale 1ns/1ps
module sim_ctl_setup_capture;
    localparam int unsigned EP = 5;
    localparam int NV = 5;
    localparam logic [31:0] ST_WORD   = 32'h0003_0085;
    localparam logic [31:0] MARK_WORD = 32'h0002_0005;
    localparam logic [31:0] MARK_OTHR = 32'h0002_0003;
    localparam logic [63:0] VEC_BYTES [NV] = '{
        64'h0000_0040_0000_0680, 64'h0000_0000_0005_0500,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
        64'h0000_0000_0001_0900};
    localparam logic [1:0] VEC_CNT [NV] = '{2'd2, 2'd1, 2'd0, 2'd0, 2'd0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_vld = 1'b0;
    logic [63:0] setup_bytes = '0;
    logic        stage_adv = 1'b0;
    logic        cnt_load = 1'b0;
    logic [1:0]  cnt_load_val = '0;
    logic [1:0]  cnt_val;
    logic        q_wr_en;
    logic [31:0] q_wr_data;
    logic        pop_vld = 1'b0;
    logic [31:0] pop_word = '0;
    logic        nak_in_set, nak_out_set, setup_irq, ep_en_clr;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;  // 100 MHz

    ctl_setup_capture #(.EP_ID(EP), .CNT_W(2)) u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    // strobe, then check the three record words (R2, R5) and the counter (R3)
    task automatic setup_rec(input logic [63:0] b, input logic [1:0] exp_cnt);
        setup_vld = 1'b1; setup_bytes = b;
        nedge();
        setup_vld = 1'b0;
        chk("R2 status wr", {63'd0, q_wr_en}, 64'd1);
        chk("R2 status word", {32'd0, q_wr_data}, {32'd0, ST_WORD});
        chk("R5 nak in/out", {62'd0, nak_in_set, nak_out_set}, 64'd3);
        chk("R3 counter", {62'd0, cnt_val}, {62'd0, exp_cnt});
        nedge();
        chk("R2 word lo", {31'd0, q_wr_en, q_wr_data}, {31'd0, 1'b1, b[31:0]});
        chk("R5 nak one cycle", {62'd0, nak_in_set, nak_out_set}, 64'd0);
        nedge();
        chk("R2 word hi", {31'd0, q_wr_en, q_wr_data}, {31'd0, 1'b1, b[63:32]});
        nedge();
        chk("R2 record ends", {63'd0, q_wr_en}, 64'd0);
    endtask

    task automatic pop_expect(input logic [31:0] w, input logic exp_irq, input string req);
        pop_vld = 1'b1; pop_word = w;
        nedge();
        pop_vld = 1'b0;
        chk(req, {62'd0, setup_irq, ep_en_clr}, {62'd0, exp_irq, exp_irq});
        nedge();
        chk({req, " pulse ends"}, {62'd0, setup_irq, ep_en_clr}, 64'd0);
    endtask

    task automatic adv_expect(input logic exp_mark, input string req);
        stage_adv = 1'b1;
        nedge();
        stage_adv = 1'b0;
        chk({req, " no early write"}, {63'd0, q_wr_en}, 64'd0);
        nedge();
        chk(req, {31'd0, q_wr_en, q_wr_data},
            exp_mark ? {31'd0, 1'b1, MARK_WORD} : 64'd0);
        nedge();
        chk({req, " single"}, {63'd0, q_wr_en}, 64'd0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        nedge(); nedge();
        // R1 reset state
        chk("R1 reset outputs", {58'd0, q_wr_en, nak_in_set, nak_out_set, setup_irq, ep_en_clr, 1'b0},
            64'd0);
        chk("R1 reset counter", {62'd0, cnt_val}, 64'd0);
        rst_n = 1'b1;
        nedge();
        chk("R1 after reset", {61'd0, q_wr_en, setup_irq, nak_in_set}, 64'd0);

        // R4 plain load
        cnt_load = 1'b1; cnt_load_val = 2'd3;
        nedge();
        cnt_load = 1'b0;
        chk("R4 load", {62'd0, cnt_val}, 64'd3);

        // vector table: back-to-back SETUPs, counter runs to 0 and saturates (R3)
        for (int i = 0; i < NV; i++) begin
            setup_rec(VEC_BYTES[i], VEC_CNT[i]);
        end

        // R6 marker, R7 no second marker
        adv_expect(1'b1, "R6 marker");
        adv_expect(1'b0, "R7 second stage_adv");

        // R8 pops
        pop_expect(ST_WORD,   1'b0, "R8 status pop ignored");
        pop_expect(MARK_OTHR, 1'b0, "R8 other endpoint ignored");
        pop_expect(MARK_WORD, 1'b1, "R8 marker pop irq");

        // R7 stage_adv with no new SETUP
        adv_expect(1'b0, "R7 no setup");

        // R9 marker pop coincides with new strobe
        pop_vld = 1'b1; pop_word = MARK_WORD;
        setup_vld = 1'b1; setup_bytes = 64'h1111_2222_3333_4444;
        nedge();
        pop_vld = 1'b0; setup_vld = 1'b0;
        chk("R9 irq", {62'd0, setup_irq, ep_en_clr}, 64'd3);
        chk("R9 status", {31'd0, q_wr_en, q_wr_data}, {31'd0, 1'b1, ST_WORD});
        chk("R9 nak", {63'd0, nak_in_set}, 64'd1);
        nedge(); nedge(); nedge();

        // R4 load wins over coincident decrement, record still written
        cnt_load = 1'b1; cnt_load_val = 2'd2;
        setup_vld = 1'b1; setup_bytes = 64'hAAAA_BBBB_CCCC_DDDD;
        nedge();
        cnt_load = 1'b0; setup_vld = 1'b0;
        chk("R4 load over dec", {62'd0, cnt_val}, 64'd2);
        chk("R4 record written", {31'd0, q_wr_en, q_wr_data}, {31'd0, 1'b1, ST_WORD});
        nedge(); nedge(); nedge();

        // R7 repeated SETUP in same stage: one marker only
        setup_rec(64'h5555_6666_7777_8888, 2'd1);
        adv_expect(1'b1, "R7 marker after repeats");
        adv_expect(1'b0, "R7 no repeat marker");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule